// File: doc/BRIEF.md
# Credit-Flow Point-to-Point Link

This block joins a flit sender to a flit receiver over a point-to-point link that uses credit (window) flow control. The receiver owns a flit buffer of `DEPTH` entries and, as its first act after reset, tells the sender in one message that it may send `DEPTH` flits. The sender keeps a credit counter. Each flit it accepts from its source costs one credit. It refuses further flits while the counter is empty.

The receiver's consumer drains the buffer. Every flit removed becomes a pending credit. Pending credits are gathered into a single return message carrying a count. The message goes out once `THRESH` credits are pending, or once at least one credit has waited `TMO` cycles, so no credit is left stranded. Both directions of the link pass through a `LAT`-stage register pipeline. The buffer depth must therefore cover the round trip for the link to keep flowing.

Sender states: `TX_WAIT` (no grant seen yet), `TX_RUN` (credits available) and `TX_STALL` (counter empty). Transitions are WAIT→RUN or WAIT→STALL on the first credit message, RUN→STALL when the counter reaches zero, and STALL→RUN when credits arrive. Receiver states: `RX_GRANT` (issue the initial allotment), `RX_IDLE` (nothing pending) and `RX_HOLD` (credits pending). Transitions are GRANT→IDLE unconditionally, IDLE→HOLD on a pop, and HOLD→IDLE on a flush in a cycle with no pop. In every other case HOLD stays in HOLD.

Top module: `credit_link`

## Requirements
- R1: During and right after reset, `src_ready` and `sink_valid` are low, `credit_level` is 0 and `ret_valid` is low.
- R2: On the first clock edge after reset is released, the receiver emits one return message (`ret_valid` high, `ret_count` = `DEPTH`). The sender counts those credits `LAT`+1 edges later.
- R3: A flit is accepted on an edge where `src_valid` and `src_ready` are both high. With no credit arriving on that edge, `credit_level` falls by exactly one.
- R4: `src_ready` is high exactly when `credit_level` is non-zero. If the sink never pops, exactly `DEPTH` flits are accepted.
- R5: A credit message arriving on the same edge as an accepted flit changes `credit_level` by the message count minus one.
- R6: A pop is taken only when `sink_valid` is high. A `sink_pop` against an empty buffer creates no credit and no return message.
- R7: When at least `THRESH` credits are pending before an edge, that edge emits a message whose count equals the pending number. A pop on the same edge becomes the first credit of the next bundle.
- R8: When fewer than `THRESH` credits are pending and the oldest has waited `TMO` edges, a message carrying the pending count is emitted on the next edge.
- R9: Flits leave on `sink_data` in acceptance order. Each enters the buffer `LAT`+1 edges after acceptance, and the buffer never receives a flit while full.
- R10: `credit_level` never exceeds `DEPTH`. After all flits are drained and the link is quiet, it returns to `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Source offers a flit |
| src_data | input | DW | Flit offered by the source |
| src_ready | output | 1 | Sender holds at least one credit |
| credit_level | output | $clog2(DEPTH+1) | Sender credit counter |
| sink_valid | output | 1 | Receiver buffer holds a flit |
| sink_data | output | DW | Oldest buffered flit |
| sink_pop | input | 1 | Consumer removes the oldest flit |
| ret_valid | output | 1 | Credit return message launched this cycle |
| ret_count | output | $clog2(DEPTH+1) | Credits carried by the return message |

## Verification
Two functions can land on one edge in this design. A returning credit bundle can reach the sender on the same edge that a flit spends a credit. A pop can also happen on the same edge that a bundle is flushed. The bench provokes both by keeping the source busy and the consumer popping at random through long runs, with flow that starts and stops. It also runs a fast full drain that crosses the threshold while still popping. A behavioural reference model, built from queues of in-flight flits and bundles with their arrival edges, predicts `credit_level`, `src_ready`, the buffer head and every return message on each clock. The bench also checks that same-edge arrival and spend actually occurred.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;
    typedef enum logic [1:0] {
        TX_WAIT  = 2'd0,
        TX_RUN   = 2'd1,
        TX_STALL = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_GRANT = 2'd0,
        RX_IDLE  = 2'd1,
        RX_HOLD  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/credit_pipe.sv
module credit_pipe #(
    parameter int W   = 8,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    generate
        if (LAT == 0) begin : g_wire
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end else begin : g_regs
            logic [LAT-1:0] stg_v;
            logic [W-1:0]   stg_d [LAT];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < LAT; i++) begin
                        stg_v[i] <= 1'b0;
                        stg_d[i] <= '0;
                    end
                end else begin
                    stg_v[0] <= in_valid;
                    stg_d[0] <= in_data;
                    for (int i = 1; i < LAT; i++) begin
                        stg_v[i] <= stg_v[i-1];
                        stg_d[i] <= stg_d[i-1];
                    end
                end
            end

            assign out_valid = stg_v[LAT-1];
            assign out_data  = stg_d[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/credit_tx.sv
module credit_tx
    import credit_link_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_ready,
    output logic [CW-1:0] credit_level,
    input  logic          crd_valid,
    input  logic [CW-1:0] crd_count,
    output logic          fwd_valid,
    output logic [DW-1:0] fwd_data
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    tx_state_e     state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt, add_w, spend_w;
    logic          fire;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TX_WAIT;
            cnt       <= '0;
            fwd_valid <= 1'b0;
            fwd_data  <= '0;
        end else begin
            state     <= state_nxt;
            cnt       <= cnt_nxt;
            fwd_valid <= fire;
            if (fire) fwd_data <= src_data;
        end
    end

    // next state and outputs
    always_comb begin
        src_ready    = (state == TX_RUN);
        credit_level = cnt;
        fire         = src_valid && src_ready;
        add_w        = crd_valid ? crd_count : '0;
        spend_w      = {{(CW-1){1'b0}}, fire};
        cnt_nxt      = cnt + add_w - spend_w;
        state_nxt    = state;
        unique case (state)
            TX_WAIT:  if (crd_valid) state_nxt = (cnt_nxt != '0) ? TX_RUN : TX_STALL;
            TX_RUN:   if (cnt_nxt == '0) state_nxt = TX_STALL;
            TX_STALL: if (cnt_nxt != '0) state_nxt = TX_RUN;
            default:  state_nxt = TX_WAIT;
        endcase
    end

    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH_C); // R10
    AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_RUN) == (cnt != '0)); // R4
    AST_SPEND_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !crd_valid) |=> (cnt == $past(cnt) - 1'b1)); // R3
    AST_CREDIT_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        crd_valid |=> (cnt == $past(cnt) + $past(crd_count) - {{(CW-1){1'b0}}, $past(fire)})); // R5
endmodule

// File: rtl/credit_rx.sv
module credit_rx
    import credit_link_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 8,
    parameter int CW     = 4,
    parameter int THRESH = 4,
    parameter int TMO    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lnk_valid,
    input  logic [DW-1:0] lnk_data,
    output logic          sink_valid,
    output logic [DW-1:0] sink_data,
    input  logic          sink_pop,
    output logic          ret_valid,
    output logic [CW-1:0] ret_count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int AW = (TMO > 1) ? $clog2(TMO) : 1;
    localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
    localparam logic [CW-1:0] THRESH_C = CW'(THRESH);
    localparam logic [AW-1:0] AGE_LAST = AW'(TMO - 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    rx_state_e     state, state_nxt;
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] level, pend;
    logic [AW-1:0] age;
    logic          pop, flush;

    // state register, buffer and bundle counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_GRANT;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            level     <= '0;
            pend      <= '0;
            age       <= '0;
            ret_valid <= 1'b0;
            ret_count <= '0;
        end else begin
            state <= state_nxt;
            if (lnk_valid) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)       rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            level <= level + {{(CW-1){1'b0}}, lnk_valid} - {{(CW-1){1'b0}}, pop};
            if (state == RX_GRANT) pend <= '0;
            else if (flush)        pend <= {{(CW-1){1'b0}}, pop};
            else                   pend <= pend + {{(CW-1){1'b0}}, pop};
            age <= (state == RX_HOLD && state_nxt == RX_HOLD && !flush) ? age + 1'b1 : '0;
            ret_valid <= (state == RX_GRANT) || flush;
            ret_count <= (state == RX_GRANT) ? DEPTH_C : pend;
        end
    end

    always_ff @(posedge clk) begin
        if (lnk_valid) mem[wr_ptr] <= lnk_data;
    end

    // next state and outputs
    always_comb begin
        sink_valid = (level != '0);
        sink_data  = mem[rd_ptr];
        pop        = sink_pop && sink_valid;
        flush      = (state == RX_HOLD) && ((pend >= THRESH_C) || (age == AGE_LAST));
        state_nxt  = state;
        unique case (state)
            RX_GRANT: state_nxt = RX_IDLE;
            RX_IDLE:  if (pop) state_nxt = RX_HOLD;
            RX_HOLD:  if (flush && !pop) state_nxt = RX_IDLE;
            default:  state_nxt = RX_GRANT;
        endcase
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_valid |-> (level < DEPTH_C)); // R9
    AST_TIMEOUT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HOLD && age == AGE_LAST) |=> ret_valid); // R8
    AST_BUNDLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (ret_count != '0 && ret_count <= DEPTH_C)); // R7
    AST_EMPTY_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE) |-> (pend == '0)); // R6
endmodule

// File: rtl/credit_link.sv
module credit_link #(
    parameter int DW     = 8,
    parameter int DEPTH  = 8,
    parameter int THRESH = 4,
    parameter int TMO    = 8,
    parameter int LAT    = 2,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_ready,
    output logic [CW-1:0] credit_level,
    output logic          sink_valid,
    output logic [DW-1:0] sink_data,
    input  logic          sink_pop,
    output logic          ret_valid,
    output logic [CW-1:0] ret_count
);
    logic          fwd_valid, lnk_valid, crd_valid;
    logic [DW-1:0] fwd_data, lnk_data;
    logic [CW-1:0] crd_count;

    credit_tx #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .credit_level(credit_level),
        .crd_valid(crd_valid), .crd_count(crd_count),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data)
    );

    credit_pipe #(.W(DW), .LAT(LAT)) u_fwd_link (
        .clk(clk), .rst_n(rst_n),
        .in_valid(fwd_valid), .in_data(fwd_data),
        .out_valid(lnk_valid), .out_data(lnk_data)
    );

    credit_rx #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .THRESH(THRESH), .TMO(TMO)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .lnk_valid(lnk_valid), .lnk_data(lnk_data),
        .sink_valid(sink_valid), .sink_data(sink_data), .sink_pop(sink_pop),
        .ret_valid(ret_valid), .ret_count(ret_count)
    );

    credit_pipe #(.W(CW), .LAT(LAT)) u_ret_link (
        .clk(clk), .rst_n(rst_n),
        .in_valid(ret_valid), .in_data(ret_count),
        .out_valid(crd_valid), .out_data(crd_count)
    );
endmodule

// File: tb/test_credit_link.sv
module test_credit_link;
    localparam int CLK_PERIOD = 10;
    localparam int DW     = 8;
    localparam int DEPTH  = 8;
    localparam int THRESH = 4;
    localparam int TMO    = 8;
    localparam int LAT    = 2;
    localparam int CW     = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_ready, sink_valid, ret_valid;
    logic [CW-1:0] credit_level, ret_count;
    logic [DW-1:0] sink_data;
    logic          sink_pop = 1'b0;

    credit_link #(.DW(DW), .DEPTH(DEPTH), .THRESH(THRESH), .TMO(TMO), .LAT(LAT)) i_credit_link (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .credit_level(credit_level),
        .sink_valid(sink_valid), .sink_data(sink_data), .sink_pop(sink_pop),
        .ret_valid(ret_valid), .ret_count(ret_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // behavioural reference model
    int m_credits = 0;
    int m_fifo[$];
    int m_pend = 0, m_age = 0, m_st = 0;  // 0 grant, 1 idle, 2 hold
    int fl_t[$], fl_d[$], cr_t[$], cr_n[$];
    int edge_no = 0;
    bit m_ret_v = 1'b0;
    int m_ret_n = 0;
    int accepted = 0;
    int coinc = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            bit fire, pop, flush, grant, push;
            int add, pdata, nst;
            fire = src_valid && (m_credits > 0);
            pop  = sink_pop && (m_fifo.size() > 0);
            add  = 0;
            while (cr_t.size() > 0 && cr_t[0] == edge_no) begin
                add += cr_n[0];
                void'(cr_t.pop_front());
                void'(cr_n.pop_front());
            end
            push = 1'b0;
            pdata = 0;
            if (fl_t.size() > 0 && fl_t[0] == edge_no) begin
                push = 1'b1;
                pdata = fl_d[0];
                void'(fl_t.pop_front());
                void'(fl_d.pop_front());
            end
            grant = (m_st == 0);
            flush = (m_st == 2) && ((m_pend >= THRESH) || (m_age == TMO - 1));
            m_ret_v = grant || flush;
            m_ret_n = grant ? DEPTH : m_pend;
            if (m_ret_v) begin
                cr_t.push_back(edge_no + LAT + 1);
                cr_n.push_back(m_ret_n);
            end
            if (fire) begin
                fl_t.push_back(edge_no + LAT + 1);
                fl_d.push_back(int'(src_data));
                accepted++;
            end
            if (fire && add > 0) coinc++;
            if (pop) void'(m_fifo.pop_front());
            if (push) m_fifo.push_back(pdata);
            m_credits = m_credits + add - (fire ? 1 : 0);
            if (grant) nst = 1;
            else if (m_st == 1) nst = pop ? 2 : 1;
            else nst = (flush && !pop) ? 1 : 2;
            m_age = (m_st == 2 && nst == 2 && !flush) ? m_age + 1 : 0;
            if (grant) m_pend = 0;
            else if (flush) m_pend = pop ? 1 : 0;
            else m_pend = m_pend + (pop ? 1 : 0);
            m_st = nst;
            edge_no++;
        end
    end

    // per-clock comparison, away from the active edge
    int phase = 0;  // 1 slow drain, 2 fast drain, 3 empty pops
    int slow_msgs = 0, slow_bad = 0, fast_msgs = 0, fast_bad = 0, empty_msgs = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            check(credit_level == CW'(m_credits), "R3 credit_level", int'(credit_level), m_credits);
            check(src_ready == (m_credits > 0), "R4 src_ready", int'(src_ready), int'(m_credits > 0));
            check(credit_level <= CW'(DEPTH), "R10 cap", int'(credit_level), DEPTH);
            check(sink_valid == (m_fifo.size() > 0), "R9 sink_valid", int'(sink_valid), int'(m_fifo.size() > 0));
            if (m_fifo.size() > 0)
                check(int'(sink_data) == m_fifo[0], "R9 sink_data order", int'(sink_data), m_fifo[0]);
            check(ret_valid == m_ret_v, "R7 ret_valid", int'(ret_valid), int'(m_ret_v));
            if (m_ret_v)
                check(int'(ret_count) == m_ret_n, "R7 ret_count", int'(ret_count), m_ret_n);
            if (ret_valid) begin
                if (phase == 1) begin slow_msgs++; if (ret_count != 1) slow_bad++; end
                if (phase == 2) begin fast_msgs++; if (ret_count != CW'(THRESH)) fast_bad++; end
                if (phase == 3) empty_msgs++;
            end
        end
    end

    task automatic step(input bit v, input bit p);
        @(negedge clk);
        src_valid = v;
        sink_pop  = p;
        src_data  = DW'($urandom_range(0, 255));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(src_ready == 1'b0, "R1 src_ready in reset", int'(src_ready), 0);
        check(sink_valid == 1'b0, "R1 sink_valid in reset", int'(sink_valid), 0);
        check(ret_valid == 1'b0, "R1 ret_valid in reset", int'(ret_valid), 0);
        check(credit_level == '0, "R1 credit_level in reset", int'(credit_level), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: grant message right after reset
        check(ret_valid == 1'b1, "R2 grant valid", int'(ret_valid), 1);
        check(int'(ret_count) == DEPTH, "R2 grant count", int'(ret_count), DEPTH);
        check(src_ready == 1'b0, "R2 no credit yet", int'(src_ready), 0);
        repeat (LAT + 1) @(negedge clk);
        check(int'(credit_level) == DEPTH, "R2 credits after LAT+1", int'(credit_level), DEPTH);

        // R4: fill with no pops
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check(accepted == DEPTH, "R4 accepted while sink blocked", accepted, DEPTH);
        check(src_ready == 1'b0, "R4 stalled", int'(src_ready), 0);

        // R8: slow drain, each credit returned by timeout
        phase = 1;
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 1'b1);
            for (int j = 0; j < TMO + 4; j++) step(1'b0, 1'b0);
        end
        phase = 0;
        check(slow_msgs == DEPTH, "R8 timeout message count", slow_msgs, DEPTH);
        check(slow_bad == 0, "R8 single-credit bundles", slow_bad, 0);

        // R7: refill, then fast drain crossing the threshold
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
        phase = 2;
        for (int i = 0; i < DEPTH + 4; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
        phase = 0;
        check(fast_msgs == DEPTH / THRESH, "R7 threshold message count", fast_msgs, DEPTH / THRESH);
        check(fast_bad == 0, "R7 bundle equals threshold", fast_bad, 0);
        for (int i = 0; i < 2 * LAT + TMO + 4; i++) step(1'b0, 1'b0);
        check(int'(credit_level) == DEPTH, "R10 credits restored", int'(credit_level), DEPTH);

        // R6: pops against an empty buffer
        phase = 3;
        for (int i = 0; i < 3 * TMO; i++) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        phase = 0;
        check(empty_msgs == 0, "R6 no message from empty pops", empty_msgs, 0);
        check(int'(credit_level) == DEPTH, "R6 no phantom credit", int'(credit_level), DEPTH);

        // R5: random traffic with coinciding arrivals and spends
        for (int i = 0; i < 3000; i++) begin
            bit busy = (i / 200) % 2 == 0;
            step($urandom_range(0, 3) != 0, busy ? ($urandom_range(0, 2) != 0) : ($urandom_range(0, 5) == 0));
        end
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1);
        check(coinc > 0, "R5 arrival and spend on one edge", coinc, 1);
        for (int i = 0; i < 2 * LAT + TMO + 4; i++) step(1'b0, 1'b0);
        check(int'(credit_level) == DEPTH, "R10 credits restored after traffic", int'(credit_level), DEPTH);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule